// File: doc/BRIEF.md
# Cache Line Refill Memory Controller

This block sits on the memory side of a slow memory bus and answers cache line refill requests. A request names a line. The controller then returns that line's four 32-bit words in ascending order. Timing follows a fixed DRAM model counted in bus cycles: one cycle to send the address, fifteen cycles for each DRAM access, and one cycle for each bus transfer. A build parameter selects one of three memory organizations, and each one gives its own fill length:

- a one-word-wide memory, where a fill takes 65 cycles;
- a two-word-wide memory and bus, where a fill takes 33 cycles;
- four interleaved one-word banks that are accessed in parallel, where a fill takes 20 cycles.

Each line is stored across four banks, and bank k holds word k of every line. The banks are filled through a one-word write port. That port works only while the controller is idle.

The request side is a valid/ready interface. `req_ready` is high only while the controller is idle. A request offered during a fill must be held until `req_ready` returns, and `req_line` must stay constant while `req_valid` is high. The return side carries no back-pressure. The memory bus cannot stall, so each beat must be taken in the cycle that `word_vld` shows it. `fill_done` marks the beat that carries the final word. `last_fill_cycles` reports how long the most recent fill took, counted from the address cycle to the done cycle inclusive.

Top module: `line_fill_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no fill is in progress. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and a request held during a fill starts no second fill.
- R2: The cycle after a request is taken is the address cycle and carries no word. Each DRAM access then occupies 15 cycles with `word_vld` = 0 before its data transfers.
- R3: With ORG = narrow (0), the fill makes four accesses. Each access is followed by one beat that carries one word on lane 0, and `word_vld[1]` is never set. The fill takes 65 cycles.
- R4: With ORG = wide (1), the fill makes two accesses. Each access is followed by one beat that carries two words, with lane 0 in bits [31:0] and lane 1 in bits [63:32], and `word_vld` = 2'b11. The fill takes 33 cycles.
- R5: With ORG = interleaved (2), the fill makes one access to all four banks in parallel. Four consecutive one-word beats follow on lane 0. The fill takes 20 cycles.
- R6: Words come out in ascending order. `word_idx` gives the index of the word on lane 0, and lane 1 carries word `word_idx`+1. Word k of a line is the value last written to (line, k).
- R7: `fill_done` is high exactly in the cycle of the beat that carries word 3, and `req_ready` is high in the cycle after it.
- R8: `last_fill_cycles` reads 0 after reset. It takes the length of each completed fill (65, 33 or 20) in the cycle after `fill_done`, and holds that value until the next fill completes.
- R9: A write of `wr_data` to (`wr_line`, `wr_word`) takes effect when `wr_en` is high while `req_ready` is high. A write offered during a fill has no effect on storage.
- R10: During and straight after reset, `req_ready` = 1, `word_vld` = 0, `fill_done` = 0 and `last_fill_cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refill request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_line | input | LINE_W | Line number to refill |
| wr_en | input | 1 | One-word storage write |
| wr_line | input | LINE_W | Line number of the write |
| wr_word | input | 2 | Word within the line (selects the bank) |
| wr_data | input | DATA_W | Write data |
| word_vld | output | 2 | Per-lane valid strobe of the current beat |
| word_idx | output | 2 | Index of the word on lane 0 |
| word_data | output | 2*DATA_W | Lane 0 in the low half, lane 1 in the high half |
| fill_done | output | 1 | Final beat of the fill |
| last_fill_cycles | output | CNT_W | Length in bus cycles of the last completed fill |

## Verification
Some properties are checked by embedded assertions on every cycle:

- the address cycle carries no word after a request is taken;
- beats appear only while the controller is busy;
- each beat holds no more lanes than the organization provides;
- `fill_done` coincides with a beat and is followed by `req_ready`;
- the measured fill length equals the organization's total.

Other behaviour only the bench scenarios can show. The bench runs all three organizations side by side against a behavioural timeline and checks:

- the exact cycle and index of every beat;
- the data taken from shadow storage;
- requests held off and accepted back-to-back;
- that a write offered during a fill leaves the stored line unchanged.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW      = 2'd0,
    ORG_WIDE        = 2'd1,
    ORG_INTERLEAVED = 2'd2
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } fill_st_e;

  localparam int LINE_WORDS = 4;

  // words carried by one bus beat
  function automatic int bus_words(org_e org);
    return (org == ORG_WIDE) ? 2 : 1;
  endfunction

  // DRAM accesses needed per line
  function automatic int accesses(org_e org);
    case (org)
      ORG_NARROW: return 4;
      ORG_WIDE:   return 2;
      default:    return 1;
    endcase
  endfunction

  // bus beats following each access
  function automatic int beats_per_access(org_e org);
    return (org == ORG_INTERLEAVED) ? 4 : 1;
  endfunction

  function automatic int fill_cycles(org_e org, int access_cyc);
    return 1 + accesses(org) * access_cyc + accesses(org) * beats_per_access(org);
  endfunction

endpackage

// File: rtl/lfc_bank.sv
module lfc_bank #(
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINE_W-1:0] rd_line,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [LINES];

  always_ff @(posedge clk) begin
    if (we) store[wr_line] <= wr_data;
  end

  assign rd_data = store[rd_line];

endmodule

// File: rtl/lfc_sequencer.sv
module lfc_sequencer
  import lfc_pkg::*;
#(
  parameter org_e ORG        = ORG_INTERLEAVED,
  parameter int   LINES      = 16,
  parameter int   ACCESS_CYC = 15,
  localparam int LINE_W = $clog2(LINES),
  localparam int BUS_W  = bus_words(ORG),
  localparam int BEATS  = beats_per_access(ORG),
  localparam int ACC_W  = $clog2(ACCESS_CYC + 1),
  localparam int BT_W   = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_ready,
  output logic [LINE_W-1:0] line_q,
  output logic [1:0]        word_vld,
  output logic [1:0]        word_idx,
  output logic              fill_done
);

  fill_st_e          state;
  logic [ACC_W-1:0]  acc_cnt;
  logic [BT_W-1:0]   beat_cnt;
  logic [1:0]        wptr;
  logic              last_beat;
  logic              in_xfer;

  assign in_xfer   = (state == ST_XFER);
  assign last_beat = (wptr == 2'(LINE_WORDS - BUS_W));
  assign req_ready = (state == ST_IDLE);
  assign fill_done = in_xfer && last_beat;
  assign word_idx  = in_xfer ? wptr : 2'd0;

  generate
    if (BUS_W == 2) begin : g_two_lane
      assign word_vld = in_xfer ? 2'b11 : 2'b00;
    end else begin : g_one_lane
      assign word_vld = {1'b0, in_xfer};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      acc_cnt  <= '0;
      beat_cnt <= '0;
      wptr     <= '0;
      line_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_ADDR;
            line_q <= req_line;
            wptr   <= '0;
          end
        end
        ST_ADDR: begin
          state   <= ST_ACCESS;
          acc_cnt <= ACC_W'(ACCESS_CYC - 1);
        end
        ST_ACCESS: begin
          if (acc_cnt == '0) begin
            state    <= ST_XFER;
            beat_cnt <= BT_W'(BEATS - 1);
          end else begin
            acc_cnt <= acc_cnt - 1'b1;
          end
        end
        default: begin
          wptr <= wptr + 2'(BUS_W);
          if (last_beat) begin
            state <= ST_IDLE;
          end else if (beat_cnt == '0) begin
            state   <= ST_ACCESS;
            acc_cnt <= ACC_W'(ACCESS_CYC - 1);
          end else begin
            beat_cnt <= beat_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  addr_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (word_vld == 2'b00 && !req_ready));

  // R1
  beat_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld != 2'b00) |-> !req_ready);

  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_vld) <= BUS_W);

  // R7
  done_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (word_vld[0] && word_idx == 2'(LINE_WORDS - BUS_W)));

  // R7
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> req_ready);

endmodule

// File: rtl/lfc_cycle_meter.sv
module lfc_cycle_meter #(
  parameter int CNT_W      = 8,
  parameter int EXP_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             fill_done,
  output logic [CNT_W-1:0] last_fill_cycles
);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt          <= '0;
      last_fill_cycles <= '0;
    end else if (fill_done) begin
      last_fill_cycles <= run_cnt + 1'b1;
      run_cnt          <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R3, R4, R5
  fill_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (last_fill_cycles == CNT_W'(EXP_CYCLES)));

  // R8
  length_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> $stable(last_fill_cycles));

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter org_e ORG        = ORG_INTERLEAVED,
  parameter int   DATA_W     = 32,
  parameter int   LINES      = 16,
  parameter int   ACCESS_CYC = 15,
  parameter int   CNT_W      = 8,
  localparam int LINE_W = $clog2(LINES),
  localparam int TOTAL  = fill_cycles(ORG, ACCESS_CYC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LINE_W-1:0]   req_line,
  input  logic                wr_en,
  input  logic [LINE_W-1:0]   wr_line,
  input  logic [1:0]          wr_word,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [1:0]          word_vld,
  output logic [1:0]          word_idx,
  output logic [2*DATA_W-1:0] word_data,
  output logic                fill_done,
  output logic [CNT_W-1:0]    last_fill_cycles
);

  logic [LINE_W-1:0] line_q;
  logic [DATA_W-1:0] bank_rd [LINE_WORDS];

  lfc_sequencer #(
    .ORG        (ORG),
    .LINES      (LINES),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_line  (req_line),
    .req_ready (req_ready),
    .line_q    (line_q),
    .word_vld  (word_vld),
    .word_idx  (word_idx),
    .fill_done (fill_done)
  );

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_bank
    lfc_bank #(
      .DATA_W (DATA_W),
      .LINES  (LINES)
    ) u_bank (
      .clk     (clk),
      .we      (wr_en && req_ready && (wr_word == 2'(k))),
      .wr_line (wr_line),
      .wr_data (wr_data),
      .rd_line (line_q),
      .rd_data (bank_rd[k])
    );
  end

  always_comb begin
    word_data = '0;
    if (word_vld[0]) word_data[DATA_W-1:0]        = bank_rd[word_idx];
    if (word_vld[1]) word_data[2*DATA_W-1:DATA_W] = bank_rd[word_idx + 2'd1];
  end

  lfc_cycle_meter #(
    .CNT_W      (CNT_W),
    .EXP_CYCLES (TOTAL)
  ) u_meter (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy             (!req_ready),
    .fill_done        (fill_done),
    .last_fill_cycles (last_fill_cycles)
  );

endmodule

// File: tb/line_fill_ctrl_test.sv
module line_fill_ctrl_test;
  import lfc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv [3];
  logic [3:0]  req_line = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_line = '0;
  logic [1:0]  wr_word = '0;
  logic [31:0] wr_data = '0;
  logic        rr [3];
  logic [1:0]  vld [3];
  logic [1:0]  idx [3];
  logic [63:0] dat [3];
  logic        done [3];
  logic [7:0]  lfc [3];

  int tests = 0;
  int fails = 0;
  int cyc [3];
  int last_t [3];
  int ln [3];
  logic [31:0] sh [3][16][4];
  string mtag [3] = '{"R3", "R4", "R5"};

  always #10 clk = ~clk;

  line_fill_ctrl #(.ORG(ORG_NARROW)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rr[0]), .req_line(req_line),
    .wr_en(wr_en), .wr_line(wr_line), .wr_word(wr_word), .wr_data(wr_data),
    .word_vld(vld[0]), .word_idx(idx[0]), .word_data(dat[0]), .fill_done(done[0]),
    .last_fill_cycles(lfc[0]));

  line_fill_ctrl #(.ORG(ORG_WIDE)) uut_wide (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rr[1]), .req_line(req_line),
    .wr_en(wr_en), .wr_line(wr_line), .wr_word(wr_word), .wr_data(wr_data),
    .word_vld(vld[1]), .word_idx(idx[1]), .word_data(dat[1]), .fill_done(done[1]),
    .last_fill_cycles(lfc[1]));

  line_fill_ctrl #(.ORG(ORG_INTERLEAVED)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_ready(rr[2]), .req_line(req_line),
    .wr_en(wr_en), .wr_line(wr_line), .wr_word(wr_word), .wr_data(wr_data),
    .word_vld(vld[2]), .word_idx(idx[2]), .word_data(dat[2]), .fill_done(done[2]),
    .last_fill_cycles(lfc[2]));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int n_acc(int m);
    return (m == 0) ? 4 : ((m == 1) ? 2 : 1);
  endfunction
  function automatic int n_beat(int m);
    return (m == 2) ? 4 : 1;
  endfunction
  function automatic int total(int m);
    return 1 + n_acc(m) * 15 + n_acc(m) * n_beat(m);
  endfunction

  // Expected beat in cycle c of a fill (c = 1 is the address cycle)
  function automatic void beat(input int m, input int c, output int lanes, output int widx);
    int k;
    int w;
    lanes = 0;
    widx  = 0;
    if (c < 2) return;
    k = c - 2;
    w = 0;
    for (int a = 0; a < n_acc(m); a++) begin
      if (k < 15) return;
      k -= 15;
      if (k < n_beat(m)) begin
        lanes = (m == 1) ? 2 : 1;
        widx  = w + k * lanes;
        return;
      end
      k -= n_beat(m);
      w += n_beat(m) * ((m == 1) ? 2 : 1);
    end
  endfunction

  // Reference timeline, advanced on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 3; m++) begin
        cyc[m] = 0;
        last_t[m] = 0;
      end
    end else begin
      for (int m = 0; m < 3; m++) begin
        if (cyc[m] == 0) begin
          if (wr_en) sh[m][wr_line][wr_word] = wr_data;
          if (rv[m]) begin
            cyc[m] = 1;
            ln[m] = req_line;
          end
        end else if (cyc[m] == total(m)) begin
          last_t[m] = total(m);
          cyc[m] = 0;
        end else begin
          cyc[m]++;
        end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 3; m++) begin
        int lanes;
        int wi;
        logic [1:0] ev;
        beat(m, cyc[m], lanes, wi);
        ev = (lanes == 0) ? 2'b00 : ((lanes == 1) ? 2'b01 : 2'b11);
        check(rr[m] == (cyc[m] == 0), "R1 ready", rr[m], cyc[m] == 0);
        check(vld[m] == ev, (lanes == 0) ? "R2 no beat" : mtag[m], vld[m], ev);
        if (lanes > 0) begin
          check(idx[m] == 2'(wi), "R6 word index", idx[m], wi);
          check(dat[m][31:0] == sh[m][ln[m]][wi], "R6 R9 lane0 data",
                dat[m][31:0], sh[m][ln[m]][wi]);
          if (lanes == 2)
            check(dat[m][63:32] == sh[m][ln[m]][wi + 1], "R6 lane1 data",
                  dat[m][63:32], sh[m][ln[m]][wi + 1]);
        end
        check(done[m] == (cyc[m] == total(m) && cyc[m] != 0), "R7 done", done[m],
              cyc[m] == total(m));
        check(lfc[m] == 8'(last_t[m]), "R8 last fill length", lfc[m], last_t[m]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (cyc[0] != 0 || cyc[1] != 0 || cyc[2] != 0) @(negedge clk);
  endtask

  task automatic request(input bit a, input bit b, input bit c, input int line);
    req_line = 4'(line);
    rv[0] = a; rv[1] = b; rv[2] = c;
    @(negedge clk);
    rv[0] = 1'b0; rv[1] = 1'b0; rv[2] = 1'b0;
  endtask

  task automatic write_word(input int line, input int w, input logic [31:0] d);
    wr_en = 1'b1; wr_line = 4'(line); wr_word = 2'(w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int m = 0; m < 3; m++) rv[m] = 1'b0;
    tick(3);
    // R10 reset state
    for (int m = 0; m < 3; m++) begin
      check(rr[m] == 1'b1, "R10 ready in reset", rr[m], 1);
      check(vld[m] == 2'b00, "R10 no beat in reset", vld[m], 0);
      check(done[m] == 1'b0, "R10 done low in reset", done[m], 0);
      check(lfc[m] == 8'd0, "R10 length zero in reset", lfc[m], 0);
    end
    rst_n = 1'b1;
    tick(1);

    for (int l = 0; l < 16; l++)
      for (int w = 0; w < 4; w++)
        write_word(l, w, 32'hA500_0000 + 32'(l * 16 + w));

    // all three organizations fill the same line
    request(1, 1, 1, 5);
    wait_idle();
    tick(2);

    // R1: held request on the interleaved unit, accepted back-to-back
    req_line = 4'd9;
    rv[2] = 1'b1;
    tick(45);
    rv[2] = 1'b0;
    wait_idle();

    // R9: write offered while all three are busy is ignored
    request(1, 1, 1, 2);
    tick(5);
    write_word(11, 1, 32'hDEAD_BEEF);
    wait_idle();
    request(1, 1, 1, 11);
    wait_idle();

    // R9: write while idle takes effect
    write_word(11, 3, 32'h1234_5678);
    write_word(11, 0, 32'h0BAD_F00D);
    request(1, 1, 1, 11);
    tick(3);
    request(1, 1, 1, 0);
    wait_idle();
    request(1, 1, 1, 15);
    wait_idle();
    tick(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule